// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit-Error Checker

This block measures bit errors on a received pseudo-random binary stream without any framing, sync marker or knowledge of the transmitter's initial register state or of the link delay. After a start pulse it captures the first received bits straight into its own linear feedback shift register. Once that register holds as many bits as the selected polynomial's order, the next bit of the stream is fully determined, so the register is switched to free-running generation and acts as a predictor.

From then on every valid received bit is compared with the predicted bit. Mismatches produce a one-cycle error strobe and advance a saturating error counter, and every compared bit advances a saturating bit counter. If errors arrive too densely to be isolated line errors, the checker concludes that it has lost alignment, drops its lock indication and seeds itself again from the live stream. Because alignment is taken from the data itself, the block cannot report how long the stream took to reach it.

Top module: `prbs_self_sync_checker`

## Requirements
- R1: After reset `locked`, `err_pulse`, `err_count` and `bit_count` are all zero. Until the first `start` pulse the block stays idle: received bits are neither loaded nor compared nor counted.
- R2: Loading uses the valid bits that arrive after the `start` cycle (a bit sampled in the `start` cycle is not used). `locked` rises at the clock edge that samples the n-th such valid bit, where n is the polynomial order, and not before it.
- R3: While locked, each valid bit is compared with the predictor's bit and `bit_count` grows by one per compared bit. The predictor runs on its own output and not on the received bits, so an error-free stream leaves `err_count` at zero. `bit_count` only changes while locked, or when cleared.
- R4: A compared bit that differs from the prediction sets `err_pulse` high for exactly the cycle after the sampling edge and adds one to `err_count`; a single isolated error leaves `locked` set.
- R5: Any cycle with `din_valid` low is ignored by both loading and comparison: it neither advances the load, nor changes either counter, nor raises `err_pulse`.
- R6: Counting compared bits by position, a second error whose position is at most 63 after the previous error (both fall in one 64-bit window) clears `locked` at the edge that samples it; errors 64 or more positions apart keep the lock.
- R7: After such a loss of lock the block reloads itself from the next n valid bits with no `start` needed and then locks again; during the reload the counters hold their values and are not cleared.
- R8: `poly_sel` is sampled only in the `start` cycle and picks the recurrence: 0 = x^7+x^6+1, 1 = x^15+x^14+1, 2 = x^23+x^18+1, 3 = x^31+x^28+1. A later change of `poly_sel` has no effect until the next `start`.
- R9: A `start` pulse at any time clears both counters and `locked` at that edge and begins a fresh load.
- R10: Both counters stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Received serial data bit |
| din_valid | input | 1 | High when `din` carries a bit in this cycle |
| start | input | 1 | One-cycle pulse: clear counters and begin seeding |
| poly_sel | input | 2 | Polynomial choice, sampled on `start` |
| locked | output | 1 | Predictor is seeded and comparing |
| err_pulse | output | 1 | One-cycle strobe per mismatching bit |
| err_count | output | ERR_W (32) | Saturating count of mismatching bits |
| bit_count | output | BIT_W (48) | Saturating count of compared bits |

## Verification
Clean sequences from all four polynomials, each started from an arbitrary seed, show that seeding takes exactly n valid bits and that prediction then runs without false errors. A stream built with one polynomial while the block is set to another must produce errors, which tells apart correct tap positions from a predictor that merely echoes its input. Streams with idle cycles carrying junk data separate valid-gated sampling from free sampling, and single flipped bits placed 100, 64 and 63 positions apart tell isolated errors from the dense-error condition that forces a reseed. A second instance with narrow counters exposes saturation against wrapping.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int REG_W = 31;

    typedef enum logic [1:0] {
        POLY_7  = 2'd0,
        POLY_15 = 2'd1,
        POLY_23 = 2'd2,
        POLY_31 = 2'd3
    } poly_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_TRACK = 2'd2
    } chk_state_e;

    // Commands from the controller to the predictor register
    typedef struct packed {
        logic load;   // shift the received bit in
        logic run;    // shift the predicted bit in
    } pred_cmd_t;

    // Events from the controller to the counters
    typedef struct packed {
        logic clr;
        logic bit_seen;
        logic bit_bad;
    } cnt_evt_t;

    function automatic logic [4:0] poly_order(poly_e p);
        case (p)
            POLY_7:  return 5'd7;
            POLY_15: return 5'd15;
            POLY_23: return 5'd23;
            default: return 5'd31;
        endcase
    endfunction

    // Bit k of the history is the bit received k+1 bits ago.
    function automatic logic poly_predict(logic [REG_W-1:0] h, poly_e p);
        case (p)
            POLY_7:  return h[6]  ^ h[5];
            POLY_15: return h[14] ^ h[13];
            POLY_23: return h[22] ^ h[17];
            default: return h[30] ^ h[27];
        endcase
    endfunction

endpackage

// File: rtl/prbs_chk_pred.sv
module prbs_chk_pred
    import prbs_chk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pred_cmd_t cmd,
    input  logic      din,
    input  poly_e     poly,
    output logic      exp_bit
);

    logic [REG_W-1:0] hist;

    assign exp_bit = poly_predict(hist, poly);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (cmd.load) begin
            hist <= {hist[REG_W-2:0], din};
        end else if (cmd.run) begin
            hist <= {hist[REG_W-2:0], exp_bit};
        end
    end

endmodule

// File: rtl/prbs_chk_satcnt.sv
module prbs_chk_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/prbs_chk_ctrl.sv
module prbs_chk_ctrl
    import prbs_chk_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       din,
    input  logic       din_valid,
    input  logic [1:0] poly_sel,
    input  logic       exp_bit,
    output poly_e      poly,
    output pred_cmd_t  cmd,
    output cnt_evt_t   evt,
    output logic       locked,
    output logic       err_pulse
);

    localparam int              GAP_W   = $clog2(WIN + 1);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(WIN);
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    chk_state_e       state;
    poly_e            poly_q;
    logic [4:0]       ld_cnt;
    logic [4:0]       ld_last;
    logic [GAP_W-1:0] gap;
    logic             has_prev;
    logic             cmp;
    logic             mismatch;
    logic             dense;

    assign ld_last  = poly_order(poly_q) - 5'd1;
    assign cmp      = (state == ST_TRACK) && din_valid && !start;
    assign mismatch = cmp && (din != exp_bit);
    assign dense    = has_prev && (gap < GAP_LIM);

    assign poly     = poly_q;
    assign locked   = (state == ST_TRACK);

    always_comb begin
        cmd.load     = (state == ST_LOAD) && din_valid && !start;
        cmd.run      = cmp;
        evt.clr      = start;
        evt.bit_seen = cmp;
        evt.bit_bad  = mismatch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            poly_q    <= POLY_7;
            ld_cnt    <= '0;
            gap       <= '0;
            has_prev  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= mismatch;
            if (start) begin
                state    <= ST_LOAD;
                poly_q   <= poly_e'(poly_sel);
                ld_cnt   <= '0;
                gap      <= '0;
                has_prev <= 1'b0;
            end else begin
                case (state)
                    ST_LOAD: begin
                        if (din_valid) begin
                            if (ld_cnt == ld_last) begin
                                state    <= ST_TRACK;
                                ld_cnt   <= '0;
                                gap      <= '0;
                                has_prev <= 1'b0;
                            end else begin
                                ld_cnt <= ld_cnt + 5'd1;
                            end
                        end
                    end
                    ST_TRACK: begin
                        if (mismatch) begin
                            if (dense) begin
                                state    <= ST_LOAD;
                                ld_cnt   <= '0;
                                gap      <= '0;
                                has_prev <= 1'b0;
                            end else begin
                                has_prev <= 1'b1;
                                gap      <= GAP_ONE;
                            end
                        end else if (cmp && (gap < GAP_LIM)) begin
                            gap <= gap + GAP_ONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/prbs_self_sync_checker.sv
module prbs_self_sync_checker
    import prbs_chk_pkg::*;
#(
    parameter int ERR_W = 32,
    parameter int BIT_W = 48,
    parameter int WIN   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             din_valid,
    input  logic             start,
    input  logic [1:0]       poly_sel,
    output logic             locked,
    output logic             err_pulse,
    output logic [ERR_W-1:0] err_count,
    output logic [BIT_W-1:0] bit_count
);

    poly_e     poly;
    pred_cmd_t cmd;
    cnt_evt_t  evt;
    logic      exp_bit;

    prbs_chk_ctrl #(
        .WIN(WIN)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .din      (din),
        .din_valid(din_valid),
        .poly_sel (poly_sel),
        .exp_bit  (exp_bit),
        .poly     (poly),
        .cmd      (cmd),
        .evt      (evt),
        .locked   (locked),
        .err_pulse(err_pulse)
    );

    prbs_chk_pred u_pred (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .din    (din),
        .poly   (poly),
        .exp_bit(exp_bit)
    );

    prbs_chk_satcnt #(
        .W(ERR_W)
    ) u_err_cnt (
        .clk(clk),
        .rst(rst),
        .clr(evt.clr),
        .inc(evt.bit_bad),
        .cnt(err_count)
    );

    prbs_chk_satcnt #(
        .W(BIT_W)
    ) u_bit_cnt (
        .clk(clk),
        .rst(rst),
        .clr(evt.clr),
        .inc(evt.bit_seen),
        .cnt(bit_count)
    );

endmodule

// File: rtl/prbs_chk_sva.sv
module prbs_chk_sva #(
    parameter int ERR_W = 32,
    parameter int BIT_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             din_valid,
    input logic             locked,
    input logic             err_pulse,
    input logic [ERR_W-1:0] err_count,
    input logic [BIT_W-1:0] bit_count
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;
    localparam logic [ERR_W-1:0] ERR_ONE = ERR_W'(1);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!locked && err_count == '0 && bit_count == '0)); // R9

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && $past(err_count) != ERR_MAX) |-> (err_count == $past(err_count) + ERR_ONE)); // R4

    AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> (err_count >= $past(err_count))); // R10

    AST_BITS_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> (bit_count >= $past(bit_count))); // R10

    AST_IDLE_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(din_valid) && !$past(start)) |-> ($stable(bit_count) && !err_pulse)); // R5

    AST_UNLOCK_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(start)) |-> err_pulse); // R6

    AST_COUNT_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (bit_count != $past(bit_count)) |-> ($past(locked) || $past(start))); // R3

endmodule

bind prbs_self_sync_checker prbs_chk_sva #(
    .ERR_W(ERR_W),
    .BIT_W(BIT_W)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .din_valid(din_valid),
    .locked   (locked),
    .err_pulse(err_pulse),
    .err_count(err_count),
    .bit_count(bit_count)
);

// File: tb/test_prbs_self_sync_checker.sv
module test_prbs_self_sync_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        din;
    logic        din_valid;
    logic        start;
    logic [1:0]  poly_sel;

    logic        locked, err_pulse;
    logic [31:0] err_count;
    logic [47:0] bit_count;

    logic        s_locked, s_err_pulse;
    logic [2:0]  s_err_count;
    logic [4:0]  s_bit_count;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [30:0] h;
    logic [1:0]  ref_poly;

    always #4 clk = ~clk;

    prbs_self_sync_checker i_prbs_self_sync_checker (
        .clk(clk), .rst(rst), .din(din), .din_valid(din_valid), .start(start),
        .poly_sel(poly_sel), .locked(locked), .err_pulse(err_pulse),
        .err_count(err_count), .bit_count(bit_count)
    );

    prbs_self_sync_checker #(.ERR_W(3), .BIT_W(5)) i_prbs_self_sync_checker_sat (
        .clk(clk), .rst(rst), .din(din), .din_valid(din_valid), .start(start),
        .poly_sel(poly_sel), .locked(s_locked), .err_pulse(s_err_pulse),
        .err_count(s_err_count), .bit_count(s_bit_count)
    );

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic ref_bit();
        case (ref_poly)
            2'd0:    return h[6]  ^ h[5];
            2'd1:    return h[14] ^ h[13];
            2'd2:    return h[22] ^ h[17];
            default: return h[30] ^ h[27];
        endcase
    endfunction

    task automatic send(input logic b, input logic v);
        @(negedge clk);
        din       = b;
        din_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic next_bit(output logic b);
        b = ref_bit();
        h = {h[29:0], b};
    endtask

    task automatic feed(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            logic b;
            next_bit(b);
            send(b, 1'b1);
        end
    endtask

    task automatic inject();
        logic b;
        next_bit(b);
        send(~b, 1'b1);
    endtask

    task automatic do_start(input logic [1:0] sel, input logic [1:0] stream, input logic [30:0] seed);
        @(negedge clk);
        start     = 1'b1;
        poly_sel  = sel;
        din_valid = 1'b1;
        din       = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        start     = 1'b0;
        din_valid = 1'b0;
        ref_poly  = stream;
        h         = seed;
    endtask

    task automatic t_reset();
        chk("R1", "locked after reset", locked, 0);
        chk("R1", "err_pulse after reset", err_pulse, 0);
        chk("R1", "err_count after reset", err_count, 0);
        chk("R1", "bit_count after reset", bit_count, 0);
        ref_poly = 2'd0;
        h = 31'h33;
        feed(40);
        chk("R1", "locked with no start", locked, 0);
        chk("R1", "bit_count with no start", bit_count, 0);
    endtask

    task automatic t_lock();
        do_start(2'd0, 2'd0, 31'h5A);
        chk("R9", "counters cleared by start", err_count + bit_count, 0);
        feed(6);
        chk("R2", "locked after n-1 bits", locked, 0);
        feed(1);
        chk("R2", "locked after n bits", locked, 1);
        chk("R3", "bit_count at lock", bit_count, 0);
        feed(200);
        chk("R3", "bit_count after 200 clean", bit_count, 200);
        chk("R3", "err_count after 200 clean", err_count, 0);
        chk("R10", "narrow bit_count saturated", s_bit_count, 31);
    endtask

    task automatic t_gaps();
        longint bc;
        do_start(2'd0, 2'd0, 31'h1F);
        for (int i = 0; i < 7; i++) begin
            logic b;
            send(1'b1, 1'b0);
            send(1'b0, 1'b0);
            next_bit(b);
            send(b, 1'b1);
        end
        chk("R5", "locked after 7 valid bits among junk", locked, 1);
        for (int i = 0; i < 50; i++) begin
            logic b;
            bc = bit_count;
            send(i[0], 1'b0);
            chk("R5", "bit_count on invalid cycle", bit_count, bc);
            chk("R5", "err_pulse on invalid cycle", err_pulse, 0);
            next_bit(b);
            send(b, 1'b1);
        end
        chk("R5", "bit_count counts only valid", bit_count, 50);
        chk("R5", "no errors from junk", err_count, 0);
    endtask

    task automatic t_errors();
        do_start(2'd0, 2'd0, 31'h41);
        feed(7);
        for (int k = 0; k < 9; k++) begin
            feed(99);
            inject();
            chk("R4", "err_pulse on flipped bit", err_pulse, 1);
            chk("R4", "err_count increments", err_count, k + 1);
            chk("R4", "isolated error keeps lock", locked, 1);
        end
        feed(1);
        chk("R4", "err_pulse one cycle only", err_pulse, 0);
        chk("R10", "narrow err_count saturated", s_err_count, 7);
    endtask

    task automatic t_window();
        longint bc;
        do_start(2'd1, 2'd1, 31'h1234);
        feed(15);
        chk("R8", "PRBS15 lock", locked, 1);
        inject();
        feed(62);
        inject();
        chk("R6", "errors 63 apart drop lock", locked, 0);
        chk("R6", "err_pulse on second error", err_pulse, 1);
        bc = bit_count;
        feed(14);
        chk("R7", "still reloading after n-1", locked, 0);
        feed(1);
        chk("R7", "relocked after n bits", locked, 1);
        chk("R7", "bit_count held during reload", bit_count, bc);
        chk("R7", "err_count kept", err_count, 2);
        inject();
        feed(63);
        inject();
        chk("R6", "errors 64 apart keep lock", locked, 1);
        chk("R6", "err_count after boundary pair", err_count, 4);
    endtask

    task automatic t_polys();
        do_start(2'd2, 2'd2, 31'h3ABCDE);
        poly_sel = 2'd0;
        feed(23);
        chk("R8", "PRBS23 lock", locked, 1);
        feed(300);
        chk("R8", "PRBS23 clean, poly_sel changed after start", err_count, 0);
        do_start(2'd3, 2'd3, 31'h1BADF00D);
        feed(30);
        chk("R8", "PRBS31 not locked at 30", locked, 0);
        feed(1);
        chk("R8", "PRBS31 lock", locked, 1);
        feed(300);
        chk("R8", "PRBS31 clean", err_count, 0);
        chk("R8", "PRBS31 bit_count", bit_count, 300);
        do_start(2'd0, 2'd1, 31'h777);
        feed(107);
        chk("R8", "wrong polynomial gives errors", (err_count > 0) ? 1 : 0, 1);
    endtask

    task automatic t_restart();
        do_start(2'd0, 2'd0, 31'h2B);
        feed(50);
        inject();
        @(negedge clk);
        start     = 1'b1;
        din_valid = 1'b0;
        @(posedge clk);
        #1;
        start = 1'b0;
        chk("R9", "locked cleared by start", locked, 0);
        chk("R9", "err_count cleared by start", err_count, 0);
        chk("R9", "bit_count cleared by start", bit_count, 0);
        feed(7);
        chk("R9", "fresh load after restart", locked, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        din       = 1'b0;
        din_valid = 1'b0;
        start     = 1'b0;
        poly_sel  = 2'd0;
        ref_poly  = 2'd0;
        h         = 31'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_lock();
        t_gaps();
        t_errors();
        t_window();
        t_polys();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule